// File: doc/BRIEF.md
# Protection-Granule Write Gate for a Tightly Coupled RAM

This block sits between a write channel and a small RAM that stores check bits next to its data. It judges every write beat against the protection granule of the selected scheme. A write that can form complete check bits is committed together with freshly computed check bits. A write that would leave a protected chunk half-updated is refused with an error response. The block supports four schemes: unprotected, per-byte even parity, SEC-DED over 32-bit halves, and SEC-DED over the whole 64-bit word. Check bits are written even while checking is disabled. This lets software load the RAM with checking off and switch checking on later without reinitialising.

Each beat carries a byte address, 64 data bits, 8 byte strobes and first/last markers. The beat's response comes back one cycle later. A one-cycle read port returns data, stored check bits and an uninitialized-read flag. The flag is raised when a checked read targets a word whose halves have not all been fully written since reset. A read issued in the same cycle as a write beat is dropped, and the read outputs hold their previous values. The scheme select and the check-enable input are taken on a first beat and held until the last beat of that burst.

Top module: `ecc_wr_gate`

## Requirements
- R1: With scheme 0 (none) or 1 (parity), every beat is accepted, including partial strobes. In parity mode, check bit i (rd_chk[i], i=0..7) holds the even parity of data byte i and is written only when strobe i is set.
- R2: With scheme 2 (32-bit ECC), a beat is rejected if address bits [1:0] are not zero or if either 4-strobe half is partially set. A first beat with address bit 2 set must have its lower half unstrobed, and its upper half must be full. On any other beat the lower half must be full. The upper half may be unstrobed only on a last beat that writes the lower half.
- R3: With scheme 3 (64-bit ECC), a beat is rejected unless address bits [2:0] are zero and all 8 strobes are set.
- R4: In the ECC schemes, a beat that is not first must target the word index that follows the previous beat's, otherwise it is rejected. After a rejection, the remaining beats of that burst are rejected.
- R5: Every beat gets b_valid one cycle later. b_err is 1 for a rejected beat and 0 for an accepted one. A rejected beat changes neither data nor check bits.
- R6: sticky_err is set by any rejected beat and cleared by clr_sticky. When both happen in the same cycle, setting wins.
- R7: The check code places data bit j at the j-th position, counting from 1, that is not a power of two. Check bit k is the XOR of the data at positions whose bit k is set. The top check bit is the even parity of all data and Hamming bits. In 32-bit ECC mode the lower half's 7 bits go to rd_chk[6:0] and the upper half's to rd_chk[14:8]. In 64-bit ECC mode the 8 bits go to rd_chk[7:0]. These bits are written whatever cfg_chk_en is.
- R8: rd_data, rd_chk and rd_uninit appear one cycle after rd_en. rd_uninit is 1 only if checking is enabled, the scheme is not 0, and at least one 32-bit half of the word has not had a full-strobe accepted write since reset.
- R9: The scheme and check-enable are sampled on a first beat and held for the rest of the burst, so a change mid-burst has no effect until the burst ends.
- R10: After reset, b_valid, b_err, sticky_err and rd_uninit are 0, and every word counts as unwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_scheme | input | 2 | 0 none, 1 parity, 2 ECC over 32 bits, 3 ECC over 64 bits |
| cfg_chk_en | input | 1 | Checking enable for reads |
| clr_sticky | input | 1 | Clears the sticky violation flag |
| w_valid | input | 1 | Write beat present |
| w_first | input | 1 | Beat opens a burst |
| w_last | input | 1 | Beat closes a burst |
| w_addr | input | AW | Byte address of the beat |
| w_data | input | 64 | Write data |
| w_strb | input | 8 | Byte strobes |
| b_valid | output | 1 | Response for the previous cycle's beat |
| b_err | output | 1 | Beat was rejected |
| sticky_err | output | 1 | A rejection occurred since the last clear |
| rd_en | input | 1 | Read request |
| rd_addr | input | WW | Word index to read |
| rd_data | output | 64 | Read data |
| rd_chk | output | 16 | Stored check bits |
| rd_uninit | output | 1 | Checked read of a word not fully written |

## Verification
The hardest situation to reach is a burst whose scheme changes while it is in progress. The response then depends on the held mode and on earlier rejections within the burst, not on the inputs of the current cycle. The bench opens a 64-bit ECC burst, switches the scheme select to parity between beats, and sends a partial-strobe middle beat followed by a clean last beat. Both must be refused. A parity write issued after the burst closes must then be accepted. A burst with a skipped word index is likewise followed by a clean beat to a prewritten word, to show that the poisoned burst leaves that word untouched.

// File: rtl/ecc_gate_pkg.sv
package ecc_gate_pkg;

  typedef enum logic [1:0] {
    PROT_NONE = 2'd0,
    PROT_PAR  = 2'd1,
    PROT_E32  = 2'd2,
    PROT_E64  = 2'd3
  } prot_e;

  // SEC-DED code: XOR of the positions of set data bits gives the Hamming
  // bits; an overall parity bit sits above them.
  function automatic logic [7:0] secded_code(input logic [63:0] d, input int nbits);
    logic [6:0] syn;
    logic       ov;
    int         di;
    syn = '0;
    ov  = 1'b0;
    di  = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (di < nbits) begin
          if (d[di[5:0]]) syn = syn ^ 7'(p);
        end
        di++;
      end
    end
    for (int i = 0; i < 64; i++) begin
      if (i < nbits) ov = ov ^ d[i];
    end
    ov = ov ^ (^syn);
    if (nbits == 32) secded_code = {1'b0, ov, syn[5:0]};
    else             secded_code = {ov, syn};
  endfunction

  function automatic logic [7:0] byte_parity(input logic [63:0] d);
    for (int b = 0; b < 8; b++) byte_parity[b] = ^d[b*8 +: 8];
  endfunction

endpackage

// File: rtl/mode_hold.sv
module mode_hold
  import ecc_gate_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  [1:0] cfg_scheme,
  input  logic  cfg_chk_en,
  input  logic  w_valid,
  input  logic  w_first,
  input  logic  w_last,
  output prot_e act_scheme,
  output logic  act_chk_en,
  output logic  in_burst
);
  prot_e hold_s;
  logic  hold_en;
  logic  use_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_s   <= PROT_NONE;
      hold_en  <= 1'b0;
      in_burst <= 1'b0;
    end else if (w_valid) begin
      if (w_first) begin
        hold_s  <= prot_e'(cfg_scheme);
        hold_en <= cfg_chk_en;
      end
      in_burst <= !w_last;
    end
  end

  assign use_hold   = in_burst && !(w_valid && w_first);
  assign act_scheme = use_hold ? hold_s : prot_e'(cfg_scheme);
  assign act_chk_en = use_hold ? hold_en : cfg_chk_en;
endmodule

// File: rtl/wr_rule_check.sv
module wr_rule_check
  import ecc_gate_pkg::*;
#(
  parameter int AW = 9,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  prot_e         scheme,
  input  logic          in_burst,
  input  logic          w_valid,
  input  logic          w_first,
  input  logic          w_last,
  input  logic [AW-1:0] w_addr,
  input  logic [SW-1:0] w_strb,
  output logic          beat_ok,
  output logic          beat_bad,
  output logic          lo_full,
  output logic          hi_full
);
  localparam int HS = SW / 2;
  localparam int WW = AW - 3;

  logic [WW-1:0] word, prev_word;
  logic          poison;
  logic          lo_none, hi_none, contig, upper_start;
  logic          lo_ok, hi_ok, ok;

  assign word        = w_addr[AW-1:3];
  assign lo_full     = &w_strb[HS-1:0];
  assign hi_full     = &w_strb[SW-1:HS];
  assign lo_none     = ~|w_strb[HS-1:0];
  assign hi_none     = ~|w_strb[SW-1:HS];
  assign contig      = w_first || (in_burst && !poison && word == prev_word + 1'b1);
  assign upper_start = w_first && w_addr[2];
  assign lo_ok       = upper_start ? lo_none : lo_full;
  assign hi_ok       = hi_full || (hi_none && w_last && !upper_start);

  always_comb begin
    unique case (scheme)
      PROT_E64: ok = (w_addr[2:0] == 3'd0) && (&w_strb) && contig;
      PROT_E32: ok = (w_addr[1:0] == 2'd0) && (w_first || !w_addr[2])
                     && lo_ok && hi_ok && contig;
      default:  ok = 1'b1;
    endcase
  end

  assign beat_ok  = w_valid && ok;
  assign beat_bad = w_valid && !ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_word <= '0;
      poison    <= 1'b0;
    end else if (w_valid) begin
      prev_word <= word;
      poison    <= !w_last && !ok;
    end
  end
endmodule

// File: rtl/chk_gen.sv
module chk_gen
  import ecc_gate_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 16
) (
  input  prot_e           scheme,
  input  logic            beat_ok,
  input  logic            lo_full,
  input  logic            hi_full,
  input  logic [DW-1:0]   w_data,
  input  logic [DW/8-1:0] w_strb,
  output logic [DW/8-1:0] byte_we,
  output logic [CW-1:0]   chk_we,
  output logic [CW-1:0]   chk_wd,
  output logic [1:0]      vset
);
  localparam int HW = DW / 2;

  logic [7:0] par, c_lo, c_hi, c_full;

  assign par    = byte_parity(w_data);
  assign c_lo   = secded_code({{HW{1'b0}}, w_data[HW-1:0]}, 32);
  assign c_hi   = secded_code({{HW{1'b0}}, w_data[DW-1:HW]}, 32);
  assign c_full = secded_code(w_data, 64);

  always_comb begin
    chk_we = '0;
    chk_wd = '0;
    unique case (scheme)
      PROT_PAR: begin
        chk_we = {8'h00, w_strb};
        chk_wd = {8'h00, par};
      end
      PROT_E32: begin
        chk_we = {1'b0, {7{hi_full}}, 1'b0, {7{lo_full}}};
        chk_wd = {1'b0, c_hi[6:0], 1'b0, c_lo[6:0]};
      end
      PROT_E64: begin
        chk_we = {8'h00, 8'hFF};
        chk_wd = {8'h00, c_full};
      end
      default: ;
    endcase
    if (!beat_ok) chk_we = '0;
  end

  assign byte_we = beat_ok ? w_strb : '0;
  assign vset    = beat_ok ? {hi_full, lo_full} : 2'b00;
endmodule

// File: rtl/tcm_store.sv
module tcm_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 64,
  parameter int CW    = 16,
  parameter int WW    = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [WW-1:0]   w_idx,
  input  logic [DW/8-1:0] byte_we,
  input  logic [DW-1:0]   wdata,
  input  logic [CW-1:0]   chk_we,
  input  logic [CW-1:0]   chk_wd,
  input  logic [1:0]      vset,
  input  logic            re,
  input  logic [WW-1:0]   r_idx,
  output logic [DW-1:0]   rdata,
  output logic [CW-1:0]   rchk,
  output logic [1:0]      vbits
);
  localparam int NB = DW / 8;

  logic [DW-1:0] dmem [DEPTH];
  logic [CW-1:0] cmem [DEPTH];
  logic [1:0]    vq   [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++)
      if (byte_we[b]) dmem[w_idx][b*8 +: 8] <= wdata[b*8 +: 8];
    if (re) rdata <= dmem[r_idx];
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < CW; c++)
      if (chk_we[c]) cmem[w_idx][c] <= chk_wd[c];
    if (re) rchk <= cmem[r_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) vq[i] <= 2'b00;
    end else if (|vset) begin
      vq[w_idx] <= vq[w_idx] | vset;
    end
  end

  assign vbits = vq[r_idx];
endmodule

// File: rtl/ecc_wr_gate.sv
module ecc_wr_gate
  import ecc_gate_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WW    = $clog2(DEPTH),
  parameter int AW    = WW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_scheme,
  input  logic          cfg_chk_en,
  input  logic          clr_sticky,
  input  logic          w_valid,
  input  logic          w_first,
  input  logic          w_last,
  input  logic [AW-1:0] w_addr,
  input  logic [63:0]   w_data,
  input  logic [7:0]    w_strb,
  output logic          b_valid,
  output logic          b_err,
  output logic          sticky_err,
  input  logic          rd_en,
  input  logic [WW-1:0] rd_addr,
  output logic [63:0]   rd_data,
  output logic [15:0]   rd_chk,
  output logic          rd_uninit
);
  localparam int DW = 64;
  localparam int CW = 16;

  prot_e        act_scheme;
  logic         act_chk_en, in_burst;
  logic         beat_ok, beat_bad, lo_full, hi_full;
  logic [7:0]   byte_we;
  logic [CW-1:0] chk_we, chk_wd;
  logic [1:0]   vset, vbits;
  logic         re;

  mode_hold u_mode (
    .clk(clk), .rst(rst), .cfg_scheme(cfg_scheme), .cfg_chk_en(cfg_chk_en),
    .w_valid(w_valid), .w_first(w_first), .w_last(w_last),
    .act_scheme(act_scheme), .act_chk_en(act_chk_en), .in_burst(in_burst)
  );

  wr_rule_check #(.AW(AW), .SW(DW/8)) u_rule (
    .clk(clk), .rst(rst), .scheme(act_scheme), .in_burst(in_burst),
    .w_valid(w_valid), .w_first(w_first), .w_last(w_last),
    .w_addr(w_addr), .w_strb(w_strb),
    .beat_ok(beat_ok), .beat_bad(beat_bad), .lo_full(lo_full), .hi_full(hi_full)
  );

  chk_gen #(.DW(DW), .CW(CW)) u_gen (
    .scheme(act_scheme), .beat_ok(beat_ok), .lo_full(lo_full), .hi_full(hi_full),
    .w_data(w_data), .w_strb(w_strb),
    .byte_we(byte_we), .chk_we(chk_we), .chk_wd(chk_wd), .vset(vset)
  );

  assign re = rd_en && !w_valid;

  tcm_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW), .WW(WW)) u_store (
    .clk(clk), .rst(rst), .w_idx(w_addr[AW-1:3]), .byte_we(byte_we), .wdata(w_data),
    .chk_we(chk_we), .chk_wd(chk_wd), .vset(vset),
    .re(re), .r_idx(rd_addr), .rdata(rd_data), .rchk(rd_chk), .vbits(vbits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      b_valid    <= 1'b0;
      b_err      <= 1'b0;
      sticky_err <= 1'b0;
      rd_uninit  <= 1'b0;
    end else begin
      b_valid <= w_valid;
      b_err   <= beat_bad;
      if (beat_bad)        sticky_err <= 1'b1;
      else if (clr_sticky) sticky_err <= 1'b0;
      if (re) rd_uninit <= act_chk_en && (act_scheme != PROT_NONE) && !(&vbits);
    end
  end
endmodule

// File: rtl/ecc_wr_gate_chk.sv
module ecc_wr_gate_chk #(
  parameter int WW = 6,
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    cfg_scheme,
  input logic          clr_sticky,
  input logic          w_valid,
  input logic          w_first,
  input logic [AW-1:0] w_addr,
  input logic [7:0]    w_strb,
  input logic          b_valid,
  input logic          b_err,
  input logic          sticky_err,
  input logic          rd_en,
  input logic          rd_uninit
);
  assert_resp_follows_R5: assert property (@(posedge clk) disable iff (rst)
    w_valid |=> b_valid);

  assert_open_accepts_R1: assert property (@(posedge clk) disable iff (rst)
    (w_valid && w_first && cfg_scheme[1] == 1'b0) |=> !b_err);

  assert_e64_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    (w_valid && w_first && cfg_scheme == 2'd3 && (w_strb != 8'hFF || w_addr[2:0] != 3'd0))
    |=> b_err);

  assert_e32_misalign_R2: assert property (@(posedge clk) disable iff (rst)
    (w_valid && w_first && cfg_scheme == 2'd2 && w_addr[1:0] != 2'd0) |=> b_err);

  assert_sticky_set_R6: assert property (@(posedge clk) disable iff (rst)
    (b_valid && b_err) |-> sticky_err);

  assert_sticky_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_sticky && !w_valid) |=> !sticky_err);

  assert_uninit_from_read_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_uninit) |-> ($past(rd_en) && !$past(w_valid)));
endmodule

bind ecc_wr_gate ecc_wr_gate_chk #(.WW(WW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfg_scheme(cfg_scheme), .clr_sticky(clr_sticky),
  .w_valid(w_valid), .w_first(w_first), .w_addr(w_addr), .w_strb(w_strb),
  .b_valid(b_valid), .b_err(b_err), .sticky_err(sticky_err),
  .rd_en(rd_en), .rd_uninit(rd_uninit)
);

// File: tb/ecc_wr_gate_tb.sv
`timescale 1ns/1ps
module ecc_wr_gate_tb;
  localparam int DEPTH = 64;
  localparam int WW = 6;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_scheme = 2'd0;
  logic cfg_chk_en = 1'b0;
  logic clr_sticky = 1'b0;
  logic w_valid = 1'b0, w_first = 1'b0, w_last = 1'b0;
  logic [AW-1:0] w_addr = '0;
  logic [63:0] w_data = '0;
  logic [7:0] w_strb = '0;
  logic b_valid, b_err, sticky_err;
  logic rd_en = 1'b0;
  logic [WW-1:0] rd_addr = '0;
  logic [63:0] rd_data;
  logic [15:0] rd_chk;
  logic rd_uninit;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ecc_wr_gate #(.DEPTH(DEPTH)) u_dut (.*);

  // Reference code computed per check bit, from the position rule
  function automatic logic [7:0] ref_code(input logic [63:0] d, input int n);
    int k = (n == 32) ? 6 : 7;
    logic [7:0] c = '0;
    logic ov = 1'b0;
    for (int b = 0; b < k; b++) begin
      int di = 0;
      logic acc = 1'b0;
      for (int p = 1; p <= n + k; p++) begin
        if ((p & (p - 1)) != 0) begin
          if (((p >> b) & 1) == 1) acc = acc ^ d[di];
          di++;
        end
      end
      c[b] = acc;
    end
    for (int i = 0; i < n; i++) ov = ov ^ d[i];
    for (int b = 0; b < k; b++) ov = ov ^ c[b];
    c[k] = ov;
    return c;
  endfunction

  function automatic logic [7:0] ref_par(input logic [63:0] d);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = ^d[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic first, input logic last, input int addr,
                      input logic [63:0] data, input logic [7:0] strb,
                      input logic exp_err, input string req);
    @(negedge clk);
    w_valid = 1'b1; w_first = first; w_last = last;
    w_addr = AW'(addr); w_data = data; w_strb = strb;
    @(negedge clk);
    w_valid = 1'b0; w_first = 1'b0; w_last = 1'b0;
    check({req, " b_valid"}, 64'(b_valid), 64'd1);
    check({req, " b_err"}, 64'(b_err), 64'(exp_err));
  endtask

  task automatic rd(input int idx);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = WW'(idx);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 b_valid", 64'(b_valid), 64'd0);
    check("R10 b_err", 64'(b_err), 64'd0);
    check("R10 sticky", 64'(sticky_err), 64'd0);
    check("R10 rd_uninit", 64'(rd_uninit), 64'd0);
    cfg_scheme = 2'd3; cfg_chk_en = 1'b1;
    rd(0);
    check("R10 R8 unwritten after reset", 64'(rd_uninit), 64'd1);
  endtask

  task automatic t_parity;
    logic [63:0] a = 64'h0123_4567_89AB_CDEF;
    logic [63:0] m = 64'h0123_4567_1122_3347;
    cfg_scheme = 2'd1; cfg_chk_en = 1'b0;
    beat(1, 1, 1*8, a, 8'hFF, 1'b0, "R1 parity full");
    beat(1, 1, 1*8 + 1, 64'hFFFF_FFFF_1122_3347, 8'h0F, 1'b0, "R1 parity partial");
    rd(1);
    check("R1 merged data", rd_data, m);
    check("R1 parity bits", 64'(rd_chk[7:0]), 64'(ref_par(m)));
    cfg_scheme = 2'd0;
    beat(1, 1, 5*8 + 3, 64'h55, 8'h01, 1'b0, "R1 none odd write");
  endtask

  task automatic t_ecc32;
    logic [63:0] d = 64'hDEAD_BEEF_CAFE_F00D;
    cfg_scheme = 2'd2; cfg_chk_en = 1'b1;
    beat(1, 1, 2*8, d, 8'hFF, 1'b0, "R2 full beat");
    rd(2);
    check("R7 e32 low code", 64'(rd_chk[6:0]), 64'(ref_code({32'h0, d[31:0]}, 32)));
    check("R7 e32 high code", 64'(rd_chk[14:8]), 64'(ref_code({32'h0, d[63:32]}, 32)));
    check("R8 e32 full word valid", 64'(rd_uninit), 64'd0);
    beat(1, 1, 2*8 + 2, 64'h1, 8'hFF, 1'b1, "R2 misaligned");
    beat(1, 1, 2*8, 64'h2, 8'h1F, 1'b1, "R2 partial half");
    beat(1, 1, 2*8 + 4, 64'h3, 8'hFF, 1'b1, "R2 upper start with low bytes");
    rd(2);
    check("R5 rejected leaves data", rd_data, d);
    check("R5 rejected leaves check", 64'({rd_chk[14:8], rd_chk[6:0]}),
          64'({ref_code({32'h0, d[63:32]}, 32)[6:0], ref_code({32'h0, d[31:0]}, 32)[6:0]}));
    beat(1, 1, 3*8 + 4, 64'h7777_6666_0000_0000, 8'hF0, 1'b0, "R2 upper-half start");
    rd(3);
    check("R2 upper half data", 64'(rd_data[63:32]), 64'h7777_6666);
    check("R8 half written is uninit", 64'(rd_uninit), 64'd1);
    beat(1, 1, 4*8, 64'h0000_0000_1234_5678, 8'h0F, 1'b0, "R2 lone lower half");
    beat(1, 1, 4*8, 64'h0000_0000_1234_5678, 8'hF0, 1'b1, "R2 upper missing lower");
  endtask

  task automatic t_ecc64;
    logic [63:0] d = 64'hA5A5_0F0F_3C3C_9669;
    cfg_scheme = 2'd3; cfg_chk_en = 1'b0;
    beat(1, 1, 6*8, d, 8'hFF, 1'b0, "R3 full beat");
    beat(1, 1, 6*8, 64'h0, 8'h7F, 1'b1, "R3 missing strobe");
    beat(1, 1, 6*8 + 4, 64'h0, 8'hFF, 1'b1, "R3 misaligned");
    rd(6);
    check("R7 e64 code written with checking off", 64'(rd_chk[7:0]), 64'(ref_code(d, 64)));
    check("R3 R5 data kept", rd_data, d);
    check("R8 checking off", 64'(rd_uninit), 64'd0);
    cfg_chk_en = 1'b1;
    rd(6);
    check("R8 valid after checked-off load", 64'(rd_uninit), 64'd0);
    rd(30);
    check("R8 unwritten checked", 64'(rd_uninit), 64'd1);
    cfg_scheme = 2'd0;
    rd(30);
    check("R8 scheme none never uninit", 64'(rd_uninit), 64'd0);
  endtask

  task automatic t_burst;
    logic [63:0] keep = 64'h1111_2222_3333_4444;
    cfg_scheme = 2'd3; cfg_chk_en = 1'b1;
    beat(1, 0, 8*8, 64'h8, 8'hFF, 1'b0, "R4 burst beat 0");
    beat(0, 0, 9*8, 64'h9, 8'hFF, 1'b0, "R4 burst beat 1");
    beat(0, 1, 10*8, 64'hA, 8'hFF, 1'b0, "R4 burst beat 2");
    rd(9);
    check("R4 burst middle data", rd_data, 64'h9);
    beat(1, 1, 15*8, keep, 8'hFF, 1'b0, "R4 prewrite");
    beat(1, 0, 12*8, 64'hC, 8'hFF, 1'b0, "R4 gap first");
    beat(0, 0, 14*8, 64'hE, 8'hFF, 1'b1, "R4 skipped word");
    beat(0, 1, 15*8, 64'hF, 8'hFF, 1'b1, "R4 poisoned tail");
    rd(15);
    check("R4 poisoned word kept", rd_data, keep);
  endtask

  task automatic t_sticky;
    check("R6 sticky after error", 64'(sticky_err), 64'd1);
    @(negedge clk); clr_sticky = 1'b1;
    @(negedge clk); clr_sticky = 1'b0;
    check("R6 sticky cleared", 64'(sticky_err), 64'd0);
    cfg_scheme = 2'd3;
    @(negedge clk);
    clr_sticky = 1'b1;
    w_valid = 1'b1; w_first = 1'b1; w_last = 1'b1; w_addr = AW'(7*8); w_strb = 8'h01;
    @(negedge clk);
    clr_sticky = 1'b0; w_valid = 1'b0;
    check("R6 set wins over clear", 64'(sticky_err), 64'd1);
  endtask

  task automatic t_hold;
    cfg_scheme = 2'd3; cfg_chk_en = 1'b1;
    beat(1, 0, 20*8, 64'h20, 8'hFF, 1'b0, "R9 first under e64");
    cfg_scheme = 2'd1;
    beat(0, 0, 21*8, 64'h21, 8'h0F, 1'b1, "R9 held scheme mid-burst");
    beat(0, 1, 22*8, 64'h22, 8'hFF, 1'b1, "R9 R4 tail after reject");
    beat(1, 1, 23*8, 64'h23, 8'h0F, 1'b0, "R9 new scheme after burst");
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_parity();
    t_ecc32();
    t_ecc64();
    t_burst();
    t_sticky();
    t_hold();
    summary();
    $finish;
  end
endmodule